// File: doc/BRIEF.md
# Wrapping Sequential Link Request Generator

This block turns a single trigger into a train of link service requests. The requests go to a contiguous run of channels in a 16-channel system. The run is given by a 4-bit first channel and a length from 1 to 8. Channel numbers count upward and wrap from 15 back to 0. For example, a first channel of 15 with a length of 4 reaches channels 15, 0, 1 and 2, in that order.

Each request is a one-cycle strobe carrying a 4-bit channel number. Every linked channel takes two clock cycles: a strobe cycle followed by a quiet cycle. Each request also raises that channel's bit in a 16-bit pending vector. The bit stays up until the target channel acknowledges it.

A trigger counts only when the triggering channel has its link-mode bit set. The first channel and the length are captured when the trigger is accepted, so the host may change them freely afterwards. An illegal length produces no requests and raises a sticky error flag. A legal trigger that arrives during a sequence waits in one holding slot and starts as soon as the current sequence ends.

Top module: `link_seq_gen`

## Requirements
- R1: With the block idle, a trigger sampled at a clock edge, with link-mode high and a legal length, gives a request strobe in the next cycle. That strobe carries the captured first channel.
- R2: Within a sequence, each request's channel is the previous channel plus one, modulo 16 (15 is followed by 0).
- R3: A sequence of length L (1 to 8) gives exactly L strobes, one every second cycle, with no strobe in between. The busy flag is high for 2*L cycles, starting in the cycle after acceptance, and low after that when nothing is queued.
- R4: A trigger with the link-mode bit low has no effect: no strobe, busy stays low and the error flag stays low.
- R5: A trigger with link-mode high and a length of 0 or 9 to 15 produces no strobe and no busy. It sets the error flag. The error flag then stays high until reset.
- R6: The first channel and the length are captured when the trigger is accepted. Changes to those inputs afterwards do not alter the running sequence.
- R7: A strobe to channel c sets bit c of the pending vector from the next cycle. The bit stays set until ack_i bit c is high at a clock edge, which clears it. A strobe and an acknowledge for the same channel at the same edge leave the bit set.
- R8: A legal trigger accepted while busy is held in one slot. Its first strobe appears in the cycle right after the last quiet cycle of the running sequence, and busy stays high across the handover. Further legal triggers that arrive while the slot is full are discarded.
- R9: After reset there is no strobe, busy is low, the pending vector is zero and the error flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | One-cycle trigger from the counting channel |
| trig_link_mode_i | input | 1 | Link-mode bit of the triggering channel |
| start_ch_i | input | 4 | First channel of the run |
| blk_len_i | input | 4 | Number of channels in the run (legal 1 to 8) |
| ack_i | input | 16 | Per-channel acknowledge, clears pending bits |
| lnk_req_o | output | 1 | Request strobe |
| lnk_ch_o | output | 4 | Channel addressed by the strobe |
| busy_o | output | 1 | High while a sequence is being issued |
| pend_o | output | 16 | Pending link flags, one per channel |
| len_err_o | output | 1 | Sticky illegal-length flag |

## Verification
Several properties are checked by the assertions on every cycle. A strobe is never followed directly by another strobe. A quiet cycle inside a sequence leads to the next strobe on the wrapped successor channel. Each launch begins with a strobe on the captured channel and only ever carries a legal length. Triggers that are rejected never launch. The error flag never falls, and the pending vector follows its strobes and acknowledges.

Other behaviour can only be shown by the bench's scenarios. These are the exact strobe count per run, the channel sequence over every first channel and length, and the timing of the queued handover. They also include dropping a third trigger, immunity to input changes after capture, and the state of the pending vector after whole runs.

// File: rtl/link_seq_pkg.sv
package link_seq_pkg;

  // Phase within one linked channel: strobe cycle, then a quiet cycle.
  typedef enum logic {
    PH_ISSUE = 1'b0,
    PH_GAP   = 1'b1
  } lsq_phase_e;

  // Successor of a channel number, wrapping at the channel count.
  function automatic int wrap_next(input int ch, input int nch);
    return (ch + 1) % nch;
  endfunction

  // A run length is usable when it lies in 1..max_len.
  function automatic bit len_legal(input int len, input int max_len);
    return (len >= 1) && (len <= max_len);
  endfunction

endpackage

// File: rtl/lsq_slot.sv
module lsq_slot
  import link_seq_pkg::*;
#(
  parameter int CH_W    = 4,
  parameter int LEN_W   = 4,
  parameter int MAX_LEN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic             mode_i,
  input  logic [CH_W-1:0]  start_ch_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             eng_ready_i,
  output logic             launch_o,
  output logic [CH_W-1:0]  launch_ch_o,
  output logic [LEN_W-1:0] launch_len_o,
  output logic             err_o
);

  logic             q_vld;
  logic [CH_W-1:0]  q_ch;
  logic [LEN_W-1:0] q_len;
  logic             err_q;

  // Named trigger events, shared by the logic and the assertions.
  logic len_ok;
  logic take;
  logic bad;

  assign len_ok = len_legal(int'(len_i), MAX_LEN);
  assign take   = trig_i & mode_i & len_ok;
  assign bad    = trig_i & mode_i & ~len_ok;

  // The held trigger goes first; a fresh one passes straight through only when the slot is empty.
  assign launch_o     = eng_ready_i & (q_vld | take);
  assign launch_ch_o  = q_vld ? q_ch  : start_ch_i;
  assign launch_len_o = q_vld ? q_len : len_i;
  assign err_o        = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_vld <= 1'b0;
      q_ch  <= '0;
      q_len <= '0;
      err_q <= 1'b0;
    end else begin
      if (bad) err_q <= 1'b1;
      // Store when the slot is freed this cycle, or when it is empty and the engine cannot take the trigger.
      if (take && (q_vld ? eng_ready_i : !eng_ready_i)) begin
        q_vld <= 1'b1;
        q_ch  <= start_ch_i;
        q_len <= len_i;
      end else if (eng_ready_i) begin
        q_vld <= 1'b0;
      end
    end
  end

  // R4: without the link-mode bit nothing is launched (unless an older trigger is held).
  assert_no_launch_nomode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && !mode_i && !q_vld) |-> !launch_o);

  // R5: an illegal length never launches.
  assert_no_launch_badlen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bad && !q_vld) |-> !launch_o);

  // R5: the error flag never falls outside reset.
  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  // R3: every launch carries a legal length.
  assert_launch_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    launch_o |-> len_legal(int'(launch_len_o), MAX_LEN));

endmodule

// File: rtl/lsq_engine.sv
module lsq_engine
  import link_seq_pkg::*;
#(
  parameter int NCH   = 16,
  parameter int LEN_W = 4,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CH_W-1:0]  start_ch_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             req_o,
  output logic [CH_W-1:0]  ch_o,
  output logic             busy_o,
  output logic             ready_o
);

  logic             busy_q;
  lsq_phase_e       phase_q;
  logic [CH_W-1:0]  ch_q;
  logic [LEN_W-1:0] left_q;

  // Named events: the final quiet cycle of a run, and the wrapped successor channel.
  logic            finish;
  logic [CH_W-1:0] ch_succ;

  assign finish  = busy_q && (phase_q == PH_GAP) && (left_q == LEN_W'(1));
  assign ch_succ = CH_W'(wrap_next(int'(ch_q), NCH));

  assign req_o   = busy_q && (phase_q == PH_ISSUE);
  assign ch_o    = ch_q;
  assign busy_o  = busy_q;
  assign ready_o = !busy_q || finish;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      phase_q <= PH_ISSUE;
      ch_q    <= '0;
      left_q  <= '0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      phase_q <= PH_ISSUE;
      ch_q    <= start_ch_i;
      left_q  <= len_i;
    end else if (busy_q) begin
      if (phase_q == PH_ISSUE) begin
        phase_q <= PH_GAP;
      end else if (finish) begin
        busy_q  <= 1'b0;
        phase_q <= PH_ISSUE;
      end else begin
        phase_q <= PH_ISSUE;
        left_q  <= left_q - LEN_W'(1);
        ch_q    <= ch_succ;
      end
    end
  end

  // R1: a launch gives a strobe on the captured channel in the next cycle.
  assert_launch_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (req_o && ch_o == $past(start_ch_i)));

  // R3: two strobes are never adjacent.
  assert_req_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |=> !req_o);

  // R2: a quiet cycle that is not the last one leads to a strobe on the next channel, wrapped.
  assert_wrap_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && phase_q == PH_GAP && left_q != LEN_W'(1)) |=>
      (req_o && ch_o == CH_W'(wrap_next(int'($past(ch_q)), NCH))));

endmodule

// File: rtl/lsq_pend.sv
module lsq_pend #(
  parameter int NCH = 16,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_i,
  input  logic [CH_W-1:0] ch_i,
  input  logic [NCH-1:0]  ack_i,
  output logic [NCH-1:0]  pend_o
);

  logic [NCH-1:0] pend_q;
  logic [NCH-1:0] set_vec;

  // One set bit per strobe; a set on the same edge as an acknowledge wins.
  always_comb begin
    set_vec = '0;
    if (req_i) set_vec[ch_i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~ack_i) | set_vec;
  end

  assign pend_o = pend_q;

  // R7: a strobe leaves its channel's bit set.
  assert_pend_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> pend_o[$past(ch_i)]);

  // R7: acknowledged bits clear when no strobe is issued.
  assert_pend_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_i && ack_i != '0) |=> ((pend_o & $past(ack_i)) == '0));

endmodule

// File: rtl/link_seq_gen.sv
module link_seq_gen #(
  parameter int NCH     = 16,
  parameter int LEN_W   = 4,
  parameter int MAX_LEN = 8,
  localparam int CH_W   = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic             trig_link_mode_i,
  input  logic [CH_W-1:0]  start_ch_i,
  input  logic [LEN_W-1:0] blk_len_i,
  input  logic [NCH-1:0]   ack_i,
  output logic             lnk_req_o,
  output logic [CH_W-1:0]  lnk_ch_o,
  output logic             busy_o,
  output logic [NCH-1:0]   pend_o,
  output logic             len_err_o
);

  logic             eng_ready;
  logic             launch;
  logic [CH_W-1:0]  launch_ch;
  logic [LEN_W-1:0] launch_len;

  lsq_slot #(.CH_W(CH_W), .LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_slot (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig_i       (trig_i),
    .mode_i       (trig_link_mode_i),
    .start_ch_i   (start_ch_i),
    .len_i        (blk_len_i),
    .eng_ready_i  (eng_ready),
    .launch_o     (launch),
    .launch_ch_o  (launch_ch),
    .launch_len_o (launch_len),
    .err_o        (len_err_o)
  );

  lsq_engine #(.NCH(NCH), .LEN_W(LEN_W)) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (launch),
    .start_ch_i (launch_ch),
    .len_i      (launch_len),
    .req_o      (lnk_req_o),
    .ch_o       (lnk_ch_o),
    .busy_o     (busy_o),
    .ready_o    (eng_ready)
  );

  lsq_pend #(.NCH(NCH)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (lnk_req_o),
    .ch_i   (lnk_ch_o),
    .ack_i  (ack_i),
    .pend_o (pend_o)
  );

  // R8: a handover from the slot keeps busy high.
  assert_busy_handover_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && launch) |=> busy_o);

endmodule

// File: tb/link_seq_gen_tb.sv
module link_seq_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig = 1'b0;
  logic        mode = 1'b0;
  logic [3:0]  start_ch = '0;
  logic [3:0]  blk_len = '0;
  logic [15:0] ack = '0;
  logic        lnk_req;
  logic [3:0]  lnk_ch;
  logic        busy;
  logic [15:0] pend;
  logic        len_err;

  int nchk  = 0;
  int nfail = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  link_seq_gen u_dut (
    .clk              (clk),
    .rst_n            (rst_n),
    .trig_i           (trig),
    .trig_link_mode_i (mode),
    .start_ch_i       (start_ch),
    .blk_len_i        (blk_len),
    .ack_i            (ack),
    .lnk_req_o        (lnk_req),
    .lnk_ch_o         (lnk_ch),
    .busy_o           (busy),
    .pend_o           (pend),
    .len_err_o        (len_err)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic logic [15:0] run_mask(input int s, input int l);
    logic [15:0] m = '0;
    for (int i = 0; i < l; i++) m[(s + i) % 16] = 1'b1;
    return m;
  endfunction

  // Expected outputs in cycle c (1 = first cycle after acceptance): run 1 (s1,l1), then run 2 (s2,l2).
  task automatic expect_cycle(input int c, input int s1, input int l1, input int s2, input int l2);
    bit eb, er;
    int ec, j;
    eb = 0; er = 0; ec = 0;
    if (c <= 2 * l1) begin
      j = c - 1; eb = 1; er = (j % 2 == 0); ec = (s1 + j / 2) % 16;
    end else if (c <= 2 * (l1 + l2)) begin
      j = c - 1 - 2 * l1; eb = 1; er = (j % 2 == 0); ec = (s2 + j / 2) % 16;
    end
    chk(busy == eb, "R3 busy", int'(busy), int'(eb));
    chk(lnk_req == er, "R3 strobe", int'(lnk_req), int'(er));
    if (er) chk(int'(lnk_ch) == ec, "R1/R2 channel", int'(lnk_ch), ec);
  endtask

  task automatic do_reset();
    trig = 0; mode = 0; ack = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic clear_pend();
    ack = 16'hFFFF;
    @(negedge clk);
    ack = '0;
    chk(pend == 16'h0, "R7 ack clears", int'(pend), 0);
  endtask

  initial begin
    do_reset();
    // R9: reset state
    chk(lnk_req == 0, "R9 strobe", int'(lnk_req), 0);
    chk(busy == 0, "R9 busy", int'(busy), 0);
    chk(pend == 0, "R9 pend", int'(pend), 0);
    chk(len_err == 0, "R9 err", int'(len_err), 0);

    // R1 R2 R3 R6 R7: sweep of every first channel and every legal length
    for (int s = 0; s < 16; s++) begin
      for (int l = 1; l <= 8; l++) begin
        trig = 1; mode = 1; start_ch = 4'(s); blk_len = 4'(l);
        @(negedge clk);
        trig = 0; start_ch = 4'(~s); blk_len = 4'(9 - l);   // R6: inputs move after capture
        for (int c = 1; c <= 2 * l + 2; c++) begin
          expect_cycle(c, s, l, 0, 0);
          @(negedge clk);
        end
        chk(pend == run_mask(s, l), "R7 pend after run", int'(pend), int'(run_mask(s, l)));
        clear_pend();
      end
    end

    // R4: trigger without the link-mode bit
    trig = 1; mode = 0; start_ch = 4'd2; blk_len = 4'd3;
    @(negedge clk);
    trig = 0;
    for (int c = 1; c <= 4; c++) begin
      chk(lnk_req == 0 && busy == 0, "R4 ignored", int'(lnk_req | busy), 0);
      @(negedge clk);
    end
    chk(len_err == 0, "R4 no error", int'(len_err), 0);
    chk(pend == 0, "R4 no pend", int'(pend), 0);

    // R7: a strobe and an acknowledge on the same edge, then persistence, then a selective acknowledge
    trig = 1; mode = 1; start_ch = 4'd5; blk_len = 4'd1;
    @(negedge clk);
    trig = 0; ack = 16'hFFFF;          // high during the strobe cycle only
    chk(lnk_req == 1 && lnk_ch == 4'd5, "R1 strobe ch5", int'(lnk_ch), 5);
    @(negedge clk);
    ack = '0;
    chk(pend == 16'h0020, "R7 set beats ack", int'(pend), 32);
    repeat (4) @(negedge clk);
    chk(pend == 16'h0020, "R7 bit held", int'(pend), 32);
    ack = 16'hFFDF;
    @(negedge clk);
    ack = '0;
    chk(pend == 16'h0020, "R7 other acks no effect", int'(pend), 32);
    ack = 16'h0020;
    @(negedge clk);
    ack = '0;
    chk(pend == 16'h0, "R7 ack own bit", int'(pend), 0);

    // R8: A (3,2) runs, B (14,3) is held, C (7,4) finds the slot full and is dropped
    trig = 1; mode = 1; start_ch = 4'd3; blk_len = 4'd2;
    @(negedge clk);
    expect_cycle(1, 3, 2, 14, 3);
    start_ch = 4'd14; blk_len = 4'd3;
    @(negedge clk);
    expect_cycle(2, 3, 2, 14, 3);
    start_ch = 4'd7; blk_len = 4'd4;
    @(negedge clk);
    trig = 0;
    for (int c = 3; c <= 14; c++) begin
      expect_cycle(c, 3, 2, 14, 3);
      @(negedge clk);
    end
    chk(pend == (run_mask(3, 2) | run_mask(14, 3)), "R8 queued run, third dropped",
        int'(pend), int'(run_mask(3, 2) | run_mask(14, 3)));
    clear_pend();

    // R5: illegal lengths, sticky error
    for (int k = 0; k < 3; k++) begin
      trig = 1; mode = 1; start_ch = 4'd1;
      blk_len = (k == 0) ? 4'd0 : (k == 1) ? 4'd9 : 4'd15;
      @(negedge clk);
      trig = 0;
      for (int c = 1; c <= 3; c++) begin
        chk(lnk_req == 0 && busy == 0, "R5 no run", int'(lnk_req | busy), 0);
        @(negedge clk);
      end
      chk(len_err == 1, "R5 error set", int'(len_err), 1);
    end
    // R5: error stays while legal runs proceed
    trig = 1; mode = 1; start_ch = 4'd0; blk_len = 4'd2;
    @(negedge clk);
    trig = 0;
    for (int c = 1; c <= 5; c++) begin
      expect_cycle(c, 0, 2, 0, 0);
      chk(len_err == 1, "R5 error sticky", int'(len_err), 1);
      @(negedge clk);
    end
    do_reset();
    chk(len_err == 0 && pend == 0 && busy == 0, "R9 reset clears", int'(len_err), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

endmodule